// File: doc/BRIEF.md
# Virtual Canvas Geometry and Pan Address Unit

This unit keeps the geometry of a framebuffer whose virtual canvas may be wider and taller than the visible screen. Software asks for a virtual width. The unit checks that width against the visible resolution. It derives the byte pitch of one canvas line from the current colour depth, then runs a multi-cycle division of the framebuffer size by that pitch to get the number of lines that fit. A request that fits is committed in a single step. A request that does not fit leaves every register untouched. A `done` pulse reports the outcome, and `accepted` tells whether the request was taken.

Writing a horizontal or vertical pan offset stores that offset. On the same clock edge the unit recomputes the display start address, expressed in 32-bit words. The address is the committed pitch times the vertical offset, plus the byte position of the horizontal offset. The scan-out logic reads this address to pan the visible window across the canvas.

Top module: `vgeom_calc`

## Requirements
- R1: After reset, `busy`, `done`, `accepted`, `virt_width`, `virt_height`, `pitch`, `pan_x`, `pan_y` and `start_addr` are all zero.
- R2: A width request below `xres` is refused. `done` is high with `accepted` low in the cycle after the request, `busy` never rises, and no geometry output changes.
- R3: When `bpp` equals 4, the candidate pitch in bytes is the requested width shifted right by one.
- R4: For any other `bpp` value, the candidate pitch is the requested width times floor((bpp+7)/8).
- R5: The virtual height is floor(`fb_size` / pitch). If it is less than the `yres` sampled with the request, the request is refused and no geometry output changes.
- R6: On acceptance, `virt_width`, `virt_height` and `pitch` change together on one edge, and `done` and `accepted` are high in the cycle that follows that edge.
- R7: A request whose candidate pitch is zero (for example `bpp` = 0) is refused in the cycle after the request, like R2.
- R8: While a division runs, `busy` is high and further width requests are ignored: they produce no `done` and do not affect the committed result.
- R9: A pan write stores its offset. On the same edge, `start_addr` becomes (pitch × `pan_y` + X byte offset) shifted right by 2.
- R10: The X byte offset is `pan_x` shifted right by one when `bpp` is 4, and otherwise `pan_x` times floor((bpp+7)/8).
- R11: `accepted` is never high without `done`, and `done` is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bpp | input | BPP_W | Colour depth in bits per pixel |
| xres | input | DIM_W | Visible horizontal resolution |
| yres | input | DIM_W | Visible vertical resolution |
| fb_size | input | FB_W | Framebuffer size in bytes |
| width_req_valid | input | 1 | Virtual width request strobe |
| width_req | input | DIM_W | Requested virtual width in pixels |
| pan_x_wr | input | 1 | Horizontal pan offset write strobe |
| pan_x_in | input | DIM_W | New horizontal pan offset |
| pan_y_wr | input | 1 | Vertical pan offset write strobe |
| pan_y_in | input | DIM_W | New vertical pan offset |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: request finished |
| accepted | output | 1 | With `done`: the request was committed |
| virt_width | output | DIM_W | Committed virtual width |
| virt_height | output | FB_W | Committed virtual height in lines |
| pitch | output | DIM_W+BPP_W-2 | Committed line pitch in bytes |
| pan_x | output | DIM_W | Stored horizontal pan offset |
| pan_y | output | DIM_W | Stored vertical pan offset |
| start_addr | output | 2*DIM_W+BPP_W-3 | Display start address in 32-bit words |

## Verification
A corrupted quotient, or a divider step count that is off, shows up at the ports as a wrong `virt_height` in the `done` cycle. It can also show up as an accept/refuse decision that flips for canvases close to the visible height, so the bench covers both a comfortable fit and a clear shortfall. A wrongly latched pitch appears twice: in `pitch` itself, and in `start_addr` on the very next pan write. Bad handling of the busy state would either commit the second, ignored request or emit an extra `done` pulse within a few cycles of the first. Both are checked at the ports right after the first request completes.

// File: rtl/vgeom_pkg.sv
package vgeom_pkg;

    typedef enum logic {
        VG_IDLE,
        VG_DIV
    } vg_state_e;

endpackage

// File: rtl/vgeom_bytes.sv
// Bytes spanned by a run of pixels at the given colour depth.
module vgeom_bytes #(
    parameter int BPP_W = 6,
    parameter int CNT_W = 16,
    parameter int OUT_W = 20
) (
    input  logic [BPP_W-1:0] bpp,
    input  logic [CNT_W-1:0] count,
    output logic [OUT_W-1:0] bytes
);
    logic [BPP_W:0] px_bytes;
    logic           nibble_mode;

    always_comb begin
        px_bytes    = ({1'b0, bpp} + (BPP_W+1)'(7)) >> 3;
        nibble_mode = (bpp == BPP_W'(4));
        if (nibble_mode)
            bytes = OUT_W'(count >> 1);
        else
            bytes = OUT_W'(count) * OUT_W'(px_bytes);
    end
endmodule

// File: rtl/vgeom_div.sv
// Restoring divider: one quotient bit per cycle, NUM_W cycles per division.
module vgeom_div #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             fin,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] den;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             fin;
    } div_s;

    div_s q, d;
    logic [DEN_W:0] trial;

    always_comb begin
        d       = q;
        d.fin   = 1'b0;
        trial   = {q.rem, q.quo[NUM_W-1]};
        if (start) begin
            d.rem = '0;
            d.quo = num;
            d.den = den;
            d.cnt = CNT_W'(NUM_W);
            d.run = 1'b1;
        end else if (q.run) begin
            if (trial >= {1'b0, q.den}) begin
                d.rem = DEN_W'(trial - {1'b0, q.den});
                d.quo = {q.quo[NUM_W-2:0], 1'b1};
            end else begin
                d.rem = DEN_W'(trial);
                d.quo = {q.quo[NUM_W-2:0], 1'b0};
            end
            d.cnt = q.cnt - CNT_W'(1);
            if (q.cnt == CNT_W'(1)) begin
                d.run = 1'b0;
                d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fin = q.fin;
    assign quo = q.quo;
endmodule

// File: rtl/vgeom_calc.sv
module vgeom_calc
    import vgeom_pkg::*;
#(
    parameter int BPP_W = 6,
    parameter int DIM_W = 16,
    parameter int FB_W  = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [BPP_W-1:0]             bpp,
    input  logic [DIM_W-1:0]             xres,
    input  logic [DIM_W-1:0]             yres,
    input  logic [FB_W-1:0]              fb_size,
    input  logic                         width_req_valid,
    input  logic [DIM_W-1:0]             width_req,
    input  logic                         pan_x_wr,
    input  logic [DIM_W-1:0]             pan_x_in,
    input  logic                         pan_y_wr,
    input  logic [DIM_W-1:0]             pan_y_in,
    output logic                         busy,
    output logic                         done,
    output logic                         accepted,
    output logic [DIM_W-1:0]             virt_width,
    output logic [FB_W-1:0]              virt_height,
    output logic [DIM_W+BPP_W-3:0]       pitch,
    output logic [DIM_W-1:0]             pan_x,
    output logic [DIM_W-1:0]             pan_y,
    output logic [2*DIM_W+BPP_W-4:0]     start_addr
);
    localparam int PITCH_W = DIM_W + BPP_W - 2;
    localparam int SUM_W   = PITCH_W + DIM_W + 1;
    localparam int SA_W    = SUM_W - 2;

    typedef struct packed {
        vg_state_e          st;
        logic               done;
        logic               acc;
        logic [DIM_W-1:0]   cand_w;
        logic [PITCH_W-1:0] cand_p;
        logic [DIM_W-1:0]   yres_lim;
        logic [DIM_W-1:0]   vw;
        logic [FB_W-1:0]    vh;
        logic [PITCH_W-1:0] pitch;
        logic [DIM_W-1:0]   pan_x;
        logic [DIM_W-1:0]   pan_y;
        logic [SA_W-1:0]    start;
    } geo_s;

    geo_s q, d;

    logic [PITCH_W-1:0] req_pitch;
    logic [PITCH_W-1:0] x_bytes;
    logic [DIM_W-1:0]   pan_x_nx;
    logic [DIM_W-1:0]   pan_y_nx;
    logic [SUM_W-1:0]   start_sum;
    logic               div_start;
    logic               div_fin;
    logic [FB_W-1:0]    div_quo;

    assign pan_x_nx = pan_x_wr ? pan_x_in : q.pan_x;
    assign pan_y_nx = pan_y_wr ? pan_y_in : q.pan_y;

    vgeom_bytes #(.BPP_W(BPP_W), .CNT_W(DIM_W), .OUT_W(PITCH_W)) u_req_bytes (
        .bpp   (bpp),
        .count (width_req),
        .bytes (req_pitch)
    );

    vgeom_bytes #(.BPP_W(BPP_W), .CNT_W(DIM_W), .OUT_W(PITCH_W)) u_pan_bytes (
        .bpp   (bpp),
        .count (pan_x_nx),
        .bytes (x_bytes)
    );

    vgeom_div #(.NUM_W(FB_W), .DEN_W(PITCH_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (fb_size),
        .den   (req_pitch),
        .fin   (div_fin),
        .quo   (div_quo)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.acc     = 1'b0;
        div_start = 1'b0;
        start_sum = SUM_W'(q.pitch) * SUM_W'(pan_y_nx) + SUM_W'(x_bytes);

        unique case (q.st)
            VG_IDLE: begin
                if (width_req_valid) begin
                    if ((width_req < xres) || (req_pitch == '0)) begin
                        d.done = 1'b1;
                    end else begin
                        div_start  = 1'b1;
                        d.st       = VG_DIV;
                        d.cand_w   = width_req;
                        d.cand_p   = req_pitch;
                        d.yres_lim = yres;
                    end
                end
            end
            VG_DIV: begin
                if (div_fin) begin
                    d.st   = VG_IDLE;
                    d.done = 1'b1;
                    if (div_quo >= FB_W'(q.yres_lim)) begin
                        d.acc   = 1'b1;
                        d.vw    = q.cand_w;
                        d.vh    = div_quo;
                        d.pitch = q.cand_p;
                    end
                end
            end
            default: d.st = VG_IDLE;
        endcase

        if (pan_x_wr || pan_y_wr) begin
            d.pan_x = pan_x_nx;
            d.pan_y = pan_y_nx;
            d.start = start_sum[SUM_W-1:2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy        = (q.st == VG_DIV);
    assign done        = q.done;
    assign accepted    = q.acc;
    assign virt_width  = q.vw;
    assign virt_height = q.vh;
    assign pitch       = q.pitch;
    assign pan_x       = q.pan_x;
    assign pan_y       = q.pan_y;
    assign start_addr  = q.start;
endmodule

// File: rtl/vgeom_calc_chk.sv
module vgeom_calc_chk #(
    parameter int DIM_W   = 16,
    parameter int FB_W    = 24,
    parameter int PITCH_W = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic               accepted,
    input logic [DIM_W-1:0]   virt_width,
    input logic [FB_W-1:0]    virt_height,
    input logic [PITCH_W-1:0] pitch,
    input logic               pan_x_wr,
    input logic [DIM_W-1:0]   pan_x_in,
    input logic [DIM_W-1:0]   pan_x,
    input logic               pan_y_wr,
    input logic [DIM_W-1:0]   pan_y_in,
    input logic [DIM_W-1:0]   pan_y
);
    a_r11_acc_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |-> done);

    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r6_geom_moves_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(virt_width) && $stable(virt_height) && $stable(pitch)));

    a_r5_refusal_keeps_geom: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !accepted) |-> ($stable(virt_width) && $stable(virt_height) && $stable(pitch)));

    a_r9_pan_x_stored: assert property (@(posedge clk) disable iff (!rst_n)
        pan_x_wr |=> (pan_x == $past(pan_x_in)));

    a_r9_pan_y_stored: assert property (@(posedge clk) disable iff (!rst_n)
        pan_y_wr |=> (pan_y == $past(pan_y_in)));
endmodule

bind vgeom_calc vgeom_calc_chk #(
    .DIM_W   (DIM_W),
    .FB_W    (FB_W),
    .PITCH_W (DIM_W + BPP_W - 2)
) u_vgeom_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .accepted    (accepted),
    .virt_width  (virt_width),
    .virt_height (virt_height),
    .pitch       (pitch),
    .pan_x_wr    (pan_x_wr),
    .pan_x_in    (pan_x_in),
    .pan_x       (pan_x),
    .pan_y_wr    (pan_y_wr),
    .pan_y_in    (pan_y_in),
    .pan_y       (pan_y)
);

// File: tb/test_vgeom_calc.sv
module test_vgeom_calc;
    localparam int BPP_W   = 6;
    localparam int DIM_W   = 16;
    localparam int FB_W    = 24;
    localparam int PITCH_W = DIM_W + BPP_W - 2;
    localparam int SA_W    = 2 * DIM_W + BPP_W - 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [BPP_W-1:0]   bpp = 6'd8;
    logic [DIM_W-1:0]   xres = 16'd640;
    logic [DIM_W-1:0]   yres = 16'd480;
    logic [FB_W-1:0]    fb_size = 24'h400000;
    logic               width_req_valid = 1'b0;
    logic [DIM_W-1:0]   width_req = '0;
    logic               pan_x_wr = 1'b0;
    logic [DIM_W-1:0]   pan_x_in = '0;
    logic               pan_y_wr = 1'b0;
    logic [DIM_W-1:0]   pan_y_in = '0;
    logic               busy, done, accepted;
    logic [DIM_W-1:0]   virt_width, pan_x, pan_y;
    logic [FB_W-1:0]    virt_height;
    logic [PITCH_W-1:0] pitch;
    logic [SA_W-1:0]    start_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    longint exp_vw = 0, exp_vh = 0, exp_p = 0, exp_px = 0, exp_py = 0;

    always #2 clk = ~clk;

    vgeom_calc #(.BPP_W(BPP_W), .DIM_W(DIM_W), .FB_W(FB_W)) i_vgeom_calc (
        .clk(clk), .rst_n(rst_n), .bpp(bpp), .xres(xres), .yres(yres),
        .fb_size(fb_size), .width_req_valid(width_req_valid), .width_req(width_req),
        .pan_x_wr(pan_x_wr), .pan_x_in(pan_x_in), .pan_y_wr(pan_y_wr), .pan_y_in(pan_y_in),
        .busy(busy), .done(done), .accepted(accepted), .virt_width(virt_width),
        .virt_height(virt_height), .pitch(pitch), .pan_x(pan_x), .pan_y(pan_y),
        .start_addr(start_addr)
    );

    function automatic longint span_bytes(int depth, longint n);
        if (depth == 4) return n / 2;
        return n * ((depth + 7) / 8);
    endfunction

    function automatic longint exp_start();
        return (exp_p * exp_py + span_bytes(int'(bpp), exp_px)) / 4;
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_geom(string req);
        check(req, longint'(virt_width), exp_vw);
        check(req, longint'(virt_height), exp_vh);
        check(req, longint'(pitch), exp_p);
    endtask

    task automatic send_req(input logic [DIM_W-1:0] w);
        @(negedge clk);
        width_req_valid = 1'b1;
        width_req = w;
        @(negedge clk);
        width_req_valid = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        got = 0;
        for (int i = 0; i < 64; i++) begin
            if (done) begin
                got = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1 busy", longint'(busy), 0);
        check("R1 done", longint'(done), 0);
        check("R1 accepted", longint'(accepted), 0);
        check_geom("R1 geometry");
        check("R1 pan_x", longint'(pan_x), 0);
        check("R1 pan_y", longint'(pan_y), 0);
        check("R1 start_addr", longint'(start_addr), 0);
    endtask

    // Covers R3 (depth 4), R4 (other depths), R5 height and R6 commit.
    task automatic t_accept(string req, int depth, int w);
        bit got;
        bpp = BPP_W'(depth);
        send_req(DIM_W'(w));
        wait_done(got);
        check({req, " done seen"}, longint'(got), 1);
        check({req, " accepted"}, longint'(accepted), 1);
        exp_vw = w;
        exp_p  = span_bytes(depth, w);
        exp_vh = longint'(fb_size) / exp_p;
        check_geom(req);
        @(negedge clk);
        check("R11 done single pulse", longint'(done), 0);
    endtask

    // R2, R5, R7 refusals: done with accepted low, nothing changes.
    task automatic t_refuse(string req, int depth, int w, bit immediate);
        bit got;
        bpp = BPP_W'(depth);
        send_req(DIM_W'(w));
        if (immediate) begin
            check({req, " done next cycle"}, longint'(done), 1);
            check({req, " busy stays low"}, longint'(busy), 0);
        end
        wait_done(got);
        check({req, " done seen"}, longint'(got), 1);
        check({req, " not accepted"}, longint'(accepted), 0);
        check_geom(req);
    endtask

    task automatic t_busy_ignore();
        bit got;
        bpp = 6'd8;
        send_req(16'd1024);
        check("R8 busy during divide", longint'(busy), 1);
        width_req_valid = 1'b1;
        width_req = 16'd2048;
        @(negedge clk);
        width_req_valid = 1'b0;
        wait_done(got);
        check("R8 first done", longint'(got), 1);
        check("R8 accepted", longint'(accepted), 1);
        exp_vw = 1024;
        exp_p  = 1024;
        exp_vh = longint'(fb_size) / 1024;
        check_geom("R8 first request kept");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 no extra done", longint'(done), 0);
        end
    endtask

    // R9 store and start address; R10 X byte offset per depth.
    task automatic t_pan(string req, bit is_x, int val);
        @(negedge clk);
        if (is_x) begin
            pan_x_wr = 1'b1;
            pan_x_in = DIM_W'(val);
            exp_px = val;
        end else begin
            pan_y_wr = 1'b1;
            pan_y_in = DIM_W'(val);
            exp_py = val;
        end
        @(negedge clk);
        pan_x_wr = 1'b0;
        pan_y_wr = 1'b0;
        check({req, " pan_x"}, longint'(pan_x), exp_px);
        check({req, " pan_y"}, longint'(pan_y), exp_py);
        check({req, " start_addr"}, longint'(start_addr), exp_start());
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_accept("R4 R6 8bpp", 8, 1024);
        t_pan("R9 y at 8bpp", 1'b0, 3);
        t_pan("R10 x at 8bpp", 1'b1, 10);
        t_accept("R3 R6 4bpp", 4, 800);
        t_pan("R10 x at 4bpp", 1'b1, 9);
        t_pan("R9 y at 4bpp", 1'b0, 2);
        t_accept("R4 24bpp", 24, 1000);
        t_pan("R10 x at 24bpp", 1'b1, 5);
        t_refuse("R2 below xres", 24, 632, 1'b1);
        t_refuse("R5 height short", 32, 4096, 1'b0);
        t_refuse("R7 zero pitch", 0, 1024, 1'b1);
        t_accept("R4 15bpp", 15, 640);
        t_busy_ignore();
        t_pan("R9 y after busy", 1'b0, 7);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule